// File: doc/BRIEF.md
# Three-way stable packet sorter

This block takes a vector of N packets (N a power of two) and reorders them into three groups. Each packet is classed by two of its bits. A packet with its valid bit clear is a void packet, whatever its address holds. A valid packet is a zero packet or a one packet according to the top bit of its destination address. The output vector holds every zero packet first, then every void packet, then every one packet.

The ordering is built from two stable binary passes with a full reversal between them. The first pass moves void packets ahead of valid ones. The reversal then puts the valid packets first. The second pass keys only valid one packets high and pushes them past the voids. This is correct only because the second pass never swaps two packets that have the same key. Each pass computes a stable rank for every packet and feeds that rank to a placement crossbar.

A build parameter can strip the address top bit from the outputs, which is what the next stage of a radix-style router needs. The sorted vector is captured in one output register.

Top module: `tsort_ternary`

## Requirements
- R1: Output lanes are grouped as all zero packets (valid bit at position Q is 1, address top bit at position Q+K is 0), then all void packets (bit Q is 0), then all one packets (bit Q is 1, bit Q+K is 1). K is log2(N) and lane j sits at bits [j*width +: width].
- R2: A packet with bit Q clear is placed as a void packet whatever value its address bits, including bit Q+K, carry.
- R3: Inside each of the three groups, packets appear in the reverse of their input lane order.
- R4: Every input packet appears exactly once at the output, with message bits 0..Q-1, the valid bit and the lower address bits unchanged.
- R5: With STRIP_MSB set, each output lane is Q+K bits wide and is the input packet without bit Q+K. With STRIP_MSB clear, each lane is the full Q+K+1 bit packet including its address top bit.
- R6: The result appears one clock edge after the input is sampled and does not change between edges. While rst_n is low the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset, clears the output register |
| pkt_in | input | N*(Q+1+K) | N packets. Per lane: message [Q-1:0], valid [Q], address [Q+K:Q+1] |
| pkt_out | output | N*OW | Sorted packets, OW = Q+K+1 or Q+K when STRIP_MSB is set |

## Verification
Two decisions land in the same cycle here: placing void packets by validity and placing valid packets by the address top bit. They collide when a void packet carries an address top bit of 1 and sits next to valid one packets, because a non-stable second pass would then mix voids with zeros. The bench provokes this by walking all 3^8 class patterns with random address bits on void lanes and random lower address bits everywhere. It judges each output by the class sequence, the tag order inside each group and a whole-vector compare, on both a stripping and a non-stripping instance.

// File: rtl/tsort_pkg.sv
package tsort_pkg;

    typedef enum logic [1:0] {
        TCLS_ZERO = 2'd0,
        TCLS_VOID = 2'd1,
        TCLS_ONE  = 2'd2
    } tcls_e;

    // Class of a packet from its valid bit and address top bit.
    function automatic tcls_e classify(input logic vld, input logic msb);
        if (!vld)
            return TCLS_VOID;
        else if (msb)
            return TCLS_ONE;
        else
            return TCLS_ZERO;
    endfunction

endpackage

// File: rtl/tsort_rank.sv
// Stable destination for every lane: key-0 lanes take their order among
// key-0 lanes, key-1 lanes follow all key-0 lanes in their own order.
module tsort_rank #(
    parameter int N = 8
) (
    input  logic [N-1:0]             key,
    output logic [N*$clog2(N)-1:0]   dest
);
    localparam int LG = $clog2(N);

    logic [LG-1:0] zero_total;
    logic [LG-1:0] zero_seen;
    logic [LG-1:0] one_seen;

    always_comb begin
        zero_total = '0;
        for (int i = 0; i < N; i++) begin
            if (!key[i])
                zero_total = zero_total + 1'b1;
        end
        zero_seen = '0;
        one_seen  = '0;
        dest      = '0;
        for (int i = 0; i < N; i++) begin
            if (key[i]) begin
                dest[i*LG +: LG] = zero_total + one_seen;
                one_seen = one_seen + 1'b1;
            end else begin
                dest[i*LG +: LG] = zero_seen;
                zero_seen = zero_seen + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tsort_xbar.sv
// Placement crossbar: each output lane collects the input lane aimed at it.
module tsort_xbar #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0]           data_in,
    input  logic [N*$clog2(N)-1:0]   dest,
    output logic [N*W-1:0]           data_out
);
    localparam int LG = $clog2(N);

    always_comb begin
        data_out = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (dest[i*LG +: LG] == LG'(j))
                    data_out[j*W +: W] = data_out[j*W +: W] | data_in[i*W +: W];
            end
        end
    end

endmodule

// File: rtl/tsort_stable_pass.sv
// One stable binary pass: rank then place.
module tsort_stable_pass #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data_in,
    input  logic [N-1:0]   key,
    output logic [N*W-1:0] data_out
);
    localparam int LG = $clog2(N);

    logic [N*LG-1:0] dest;

    tsort_rank #(.N(N)) rank_i (
        .key  (key),
        .dest (dest)
    );

    tsort_xbar #(.N(N), .W(W)) xbar_i (
        .data_in  (data_in),
        .dest     (dest),
        .data_out (data_out)
    );

endmodule

// File: rtl/tsort_ternary.sv
module tsort_ternary
    import tsort_pkg::*;
#(
    parameter int N         = 8,
    parameter int Q         = 4,
    parameter bit STRIP_MSB = 1'b1,
    localparam int K        = $clog2(N),
    localparam int PW       = Q + 1 + K,
    localparam int OW       = PW - (STRIP_MSB ? 1 : 0)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N*PW-1:0] pkt_in,
    output logic [N*OW-1:0] pkt_out
);
    localparam int VB  = Q;
    localparam int MSB = Q + K;

    logic [N-1:0]    valid_key;
    logic [N*PW-1:0] by_valid;
    logic [N*PW-1:0] flipped;
    logic [N-1:0]    one_key;
    logic [N*OW-1:0] narrow;
    logic [N*OW-1:0] sorted;

    // Pass 1: voids (key 0) ahead of valid packets (key 1).
    for (genvar i = 0; i < N; i++) begin : g_key1
        assign valid_key[i] = pkt_in[i*PW + VB];
    end

    tsort_stable_pass #(.N(N), .W(PW)) pass_valid_i (
        .data_in  (pkt_in),
        .key      (valid_key),
        .data_out (by_valid)
    );

    // End-to-end reversal, then key only valid one packets high.
    for (genvar i = 0; i < N; i++) begin : g_flip
        assign flipped[i*PW +: PW] = by_valid[(N-1-i)*PW +: PW];
        assign one_key[i] = (classify(flipped[i*PW + VB], flipped[i*PW + MSB]) == TCLS_ONE);
        assign narrow[i*OW +: OW] = flipped[i*PW +: OW];
    end

    // Pass 2 moves one packets past voids without disturbing zeros/voids.
    tsort_stable_pass #(.N(N), .W(OW)) pass_msb_i (
        .data_in  (narrow),
        .key      (one_key),
        .data_out (sorted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pkt_out <= '0;
        else
            pkt_out <= sorted;
    end

endmodule

// File: rtl/tsort_ternary_chk.sv
module tsort_ternary_chk
    import tsort_pkg::*;
#(
    parameter int N         = 8,
    parameter int Q         = 4,
    parameter bit STRIP_MSB = 1'b1,
    localparam int K        = $clog2(N),
    localparam int PW       = Q + 1 + K,
    localparam int OW       = PW - (STRIP_MSB ? 1 : 0),
    localparam int CW       = $clog2(N + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N*PW-1:0] pkt_in,
    input logic [N*OW-1:0] pkt_out
);
    logic [CW-1:0] in_zero_cnt, in_void_cnt, in_vld_cnt;
    logic [CW-1:0] out_vld_cnt, out_lead, out_edges;
    logic [OW-1:0] in_sig, out_sig;
    logic          run;

    always_comb begin
        in_zero_cnt = '0;
        in_void_cnt = '0;
        in_vld_cnt  = '0;
        in_sig      = '0;
        for (int i = 0; i < N; i++) begin
            case (classify(pkt_in[i*PW + Q], pkt_in[i*PW + Q + K]))
                TCLS_ZERO: in_zero_cnt = in_zero_cnt + 1'b1;
                TCLS_VOID: in_void_cnt = in_void_cnt + 1'b1;
                default:   ;
            endcase
            if (pkt_in[i*PW + Q])
                in_vld_cnt = in_vld_cnt + 1'b1;
            in_sig = in_sig ^ pkt_in[i*PW +: OW];
        end
        out_vld_cnt = '0;
        out_lead    = '0;
        out_edges   = '0;
        out_sig     = '0;
        run         = 1'b1;
        for (int j = 0; j < N; j++) begin
            if (pkt_out[j*OW + Q]) begin
                out_vld_cnt = out_vld_cnt + 1'b1;
                if (run)
                    out_lead = out_lead + 1'b1;
            end else begin
                run = 1'b0;
            end
            if (j < N - 1 && pkt_out[j*OW + Q] != pkt_out[(j+1)*OW + Q])
                out_edges = out_edges + 1'b1;
            out_sig = out_sig ^ pkt_out[j*OW +: OW];
        end
    end

    // R1: the leading valid run is exactly the zero group (all lanes if no voids).
    assert_zero_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(in_void_cnt) == '0) ? (out_lead == CW'(N))
                                             : (out_lead == $past(in_zero_cnt))));

    // R1: valid bits across the output form at most one void block.
    assert_single_void_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_edges <= CW'(2));

    // R2: void packets keep their count whatever their address bits.
    assert_void_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_vld_cnt == $past(in_vld_cnt)));

    // R4: the XOR of all kept packet bits survives the permutation.
    assert_payload_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_sig == $past(in_sig)));

endmodule

bind tsort_ternary tsort_ternary_chk #(
    .N(N), .Q(Q), .STRIP_MSB(STRIP_MSB)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pkt_in  (pkt_in),
    .pkt_out (pkt_out)
);

// File: tb/tsort_ternary_tb_top.sv
`timescale 1ns/1ps
module tsort_ternary_tb_top;
    localparam int N  = 8;
    localparam int Q  = 4;
    localparam int K  = 3;
    localparam int PW = Q + 1 + K;
    localparam int OW = PW - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*PW-1:0] pkt_in = '0;
    logic [N*OW-1:0] out_s;
    logic [N*PW-1:0] out_f;

    logic [PW-1:0]   lane [N];
    logic [N*PW-1:0] exp_f, prev_f;
    logic [N*OW-1:0] exp_s;
    int              n_tests = 0;
    int              n_fail  = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    tsort_ternary #(.N(N), .Q(Q), .STRIP_MSB(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_in(pkt_in), .pkt_out(out_s));

    tsort_ternary #(.N(N), .Q(Q), .STRIP_MSB(1'b0)) dut_full_i (
        .clk(clk), .rst_n(rst_n), .pkt_in(pkt_in), .pkt_out(out_f));

    // 0 zero, 1 void, 2 one
    function automatic int cls_of(input logic [PW-1:0] p);
        if (!p[Q]) return 1;
        return p[Q+K] ? 2 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic make_lane(input int i, input int c);
        logic [3:0] msg;
        logic [1:0] lo;
        logic       m;
        msg = {1'($urandom), 3'(i)};
        lo  = 2'($urandom);
        m   = (c == 2) ? 1'b1 : (c == 0) ? 1'b0 : 1'($urandom);
        lane[i] = {m, lo, (c != 1), msg};
    endtask

    task automatic run_case();
        int order [N];
        int idx;
        logic [N*2-1:0] got_c, exp_c;
        logic [N*3-1:0] got_t, exp_t;
        idx = 0;
        for (int g = 0; g < 3; g++)
            for (int i = N - 1; i >= 0; i--)
                if (cls_of(lane[i]) == g) begin
                    order[idx] = i;
                    idx++;
                end
        for (int j = 0; j < N; j++) begin
            exp_f[j*PW +: PW] = lane[order[j]];
            exp_s[j*OW +: OW] = lane[order[j]][OW-1:0];
            exp_c[j*2 +: 2]   = 2'(cls_of(lane[order[j]]));
            exp_t[j*3 +: 3]   = 3'(order[j]);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) pkt_in[i*PW +: PW] = lane[i];
        #1;
        check(out_f == prev_f, "R6", "output held before edge", 64'(out_f), 64'(prev_f));
        @(negedge clk);
        for (int j = 0; j < N; j++) begin
            got_c[j*2 +: 2] = 2'(cls_of(out_f[j*PW +: PW]));
            got_t[j*3 +: 3] = out_f[j*PW +: 3];
        end
        check(got_c == exp_c, "R1", "class sequence", 64'(got_c), 64'(exp_c));
        check(got_t == exp_t, "R3", "tag order", 64'(got_t), 64'(exp_t));
        check(out_f == exp_f, "R4", "full packets", 64'(out_f), 64'(exp_f));
        check(out_s == exp_s, "R5", "stripped packets", 64'(out_s), 64'(exp_s));
        prev_f = exp_f;
    endtask

    initial begin
        void'($urandom(32'd2024));
        prev_f = '0;
        repeat (3) @(negedge clk);
        check(out_f == '0, "R6", "reset full", 64'(out_f), 64'd0);
        check(out_s == '0, "R6", "reset stripped", 64'(out_s), 64'd0);
        rst_n = 1'b1;

        // R2: all void, address top bits set
        for (int i = 0; i < N; i++) begin
            make_lane(i, 1);
            lane[i][Q+K] = 1'b1;
        end
        run_case();
        // all zeros, all ones, alternating
        for (int i = 0; i < N; i++) make_lane(i, 0);
        run_case();
        for (int i = 0; i < N; i++) make_lane(i, 2);
        run_case();
        for (int i = 0; i < N; i++) make_lane(i, (i % 2 == 0) ? 2 : 1);
        run_case();

        // exhaustive class patterns with random address and message bits
        for (int p = 0; p < 6561; p++) begin
            int t;
            t = p;
            for (int i = 0; i < N; i++) begin
                make_lane(i, t % 3);
                t = t / 3;
            end
            run_case();
        end

        // constrained random tail
        for (int r = 0; r < 200; r++) begin
            for (int i = 0; i < N; i++) make_lane(i, int'($urandom % 3));
            run_case();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule